// File: doc/BRIEF.md
# Rollover Timer with Interrupt-Return Reload

This block is an 8-bit up-counter that runs freely and signals an interrupt request each time it wraps from its top value back to zero. A 7-bit option field picks what drives the counter. It can count every system clock cycle, or count edges on an external pin; for the pin, a separate bit selects the rising or the falling edge. A shared divide stage can sit in front of the counter. When the divider is handed to the watchdog, it no longer drives the counter, which then steps once for every source event.

Software sets a fixed interrupt period through the acknowledge strobe. When the service routine returns, it pulses the acknowledge strobe with a reload value. In that cycle the block adds the value to the counter, modulo 256, and clears the pending request. A negative reload value such as 0x27 (minus 217) makes the next wrap arrive a known number of counts later.

The request logic is a two-state machine. In **IRQ_IDLE** there is no pending request. The transition **RAISE** moves it to **IRQ_PENDING** when an increment wraps the counter while requests are enabled. The transition **CLEAR** moves it back to **IRQ_IDLE** on an acknowledge. In every other case the state holds (**HOLD**).

Top module: `rtt_rollover_timer`

## Requirements
- R1: With option bit 5 = 0 (internal source) and bit 3 = 1 (divider given to the watchdog), the counter steps by one on every clock edge that carries no acknowledge; bits 2:0 have no effect.
- R2: With option bit 3 = 0, the divider belongs to the counter. The counter then steps once per 2^(k+1) source events, where k is the code in bits 2:0 (code 0 gives 1:2, code 7 gives 1:256).
- R3: With option bit 5 = 1, the counter steps once per pin edge. The pin passes through two synchronizing flops first. Bit 4 = 0 selects rising edges and bit 4 = 1 selects falling edges. The step appears on the third clock edge after the pin changes.
- R4: When an increment takes the counter from 0xFF to 0x00 with option bit 6 = 0, the request output rises on the same edge on which the counter shows 0x00.
- R5: With option bit 6 = 1, a wrap still takes the counter to 0x00 but raises no request.
- R6: A raised request stays high until an acknowledge, even if option bit 6 is set meanwhile.
- R7: An acknowledge clears the request and loads counter + value (mod 256) on the next edge. Any increment due in that cycle is dropped, and an overflow of the addition never raises a request.
- R8: With an internal source, no divider, and every request acknowledged one cycle after it appears with value V, requests rise every (256 - V) + 1 clock cycles. For V = 0x27 this is 218 cycles.
- R9: After reset the counter reads 0x00, no request is pending and the divider is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one clock is one instruction cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_pin | input | 1 | External count pin, asynchronous |
| opt_cfg | input | 7 | Option field: [6] request disable, [5] source, [4] edge, [3] divider owner, [2:0] ratio code |
| ack_strobe | input | 1 | Interrupt-return strobe: clear request and add reload value |
| ack_value | input | 8 | Value added to the counter on acknowledge |
| count_q | output | 8 | Current counter value |
| irq_out | output | 1 | Pending rollover request |

## Verification
Several behaviours are checked by assertions on every cycle:
- a request stays held until it is acknowledged;
- an acknowledge clears the request and yields exactly the modular sum;
- the counter never moves by more than one outside an acknowledge;
- the counter steps every cycle in the undivided internal mode;
- a wrap with requests enabled always raises the request.

Other behaviours only the bench's scenarios can show:
- the divide ratios over many events;
- the three-edge pin latency;
- the rising/falling edge selection;
- the exact period of a repeated reload sequence.

The bench checks these against a behavioural model.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
    // option field positions (decoded by the counter's neighbours)
    localparam int OPT_W        = 7;
    localparam int OPT_IRQ_OFF  = 6;
    localparam int OPT_SRC_PIN  = 5;
    localparam int OPT_FALLING  = 4;
    localparam int OPT_PS_WDOG  = 3;
    localparam int OPT_CODE_LSB = 0;
    localparam int CODE_W       = 3;

    typedef enum logic {
        IRQ_IDLE    = 1'b0,
        IRQ_PENDING = 1'b1
    } irq_state_t;

    typedef enum logic {
        SRC_CYCLE = 1'b0,
        SRC_PIN   = 1'b1
    } src_sel_t;
endpackage

// File: rtl/rtt_edge_detect.sv
module rtt_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic falling_sel,
    output logic edge_pulse
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= pin_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    always_comb begin
        if (falling_sel) edge_pulse = prev_q & ~sync_q[SYNC_STAGES-1];
        else             edge_pulse = ~prev_q & sync_q[SYNC_STAGES-1];
    end
endmodule

// File: rtl/rtt_prescaler.sv
module rtt_prescaler #(
    parameter int PS_W   = 8,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              event_in,
    input  logic              owned_by_timer,
    input  logic [CODE_W-1:0] ratio_code,
    output logic              tick_out
);
    logic [PS_W-1:0] div_q;
    logic [PS_W-1:0] tap_mask;

    // bits 0..code must all be ones for a carry out of the selected tap
    always_comb begin
        for (int i = 0; i < PS_W; i++) begin
            tap_mask[i] = (i <= int'(ratio_code));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          div_q <= '0;
        else if (owned_by_timer && event_in) div_q <= div_q + PS_W'(1);
    end

    always_comb begin
        if (owned_by_timer) tick_out = event_in && ((div_q & tap_mask) == tap_mask);
        else                tick_out = event_in;
    end
endmodule

// File: rtl/rtt_irq_fsm.sv
module rtt_irq_fsm
    import rtt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_evt,
    input  logic irq_enable,
    input  logic ack,
    output logic irq
);
    irq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: begin
                if (wrap_evt && irq_enable) state_d = IRQ_PENDING;   // RAISE
            end
            IRQ_PENDING: begin
                if (ack) state_d = IRQ_IDLE;                         // CLEAR
            end
            default: state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_PENDING);
    end
endmodule

// File: rtl/rtt_rollover_timer.sv
module rtt_rollover_timer
    import rtt_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PS_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_pin,
    input  logic [OPT_W-1:0] opt_cfg,
    input  logic             ack_strobe,
    input  logic [CNT_W-1:0] ack_value,
    output logic [CNT_W-1:0] count_q,
    output logic             irq_out
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    src_sel_t    src_sel;
    logic        pin_edge;
    logic        src_event;
    logic        inc_tick;
    logic        wrap_evt;
    logic [CNT_W-1:0] cnt_r;

    assign src_sel = src_sel_t'(opt_cfg[OPT_SRC_PIN]);

    rtt_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_in      (cnt_pin),
        .falling_sel (opt_cfg[OPT_FALLING]),
        .edge_pulse  (pin_edge)
    );

    always_comb begin
        unique case (src_sel)
            SRC_CYCLE: src_event = 1'b1;
            SRC_PIN:   src_event = pin_edge;
            default:   src_event = 1'b0;
        endcase
    end

    rtt_prescaler #(.PS_W(PS_W), .CODE_W(CODE_W)) u_div (
        .clk            (clk),
        .rst_n          (rst_n),
        .event_in       (src_event),
        .owned_by_timer (~opt_cfg[OPT_PS_WDOG]),
        .ratio_code     (opt_cfg[OPT_CODE_LSB +: CODE_W]),
        .tick_out       (inc_tick)
    );

    // acknowledge replaces the increment of its cycle
    assign wrap_evt = inc_tick && !ack_strobe && (cnt_r == CNT_TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_r <= '0;
        else if (ack_strobe) cnt_r <= cnt_r + ack_value;
        else if (inc_tick)   cnt_r <= cnt_r + CNT_W'(1);
    end

    rtt_irq_fsm u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wrap_evt   (wrap_evt),
        .irq_enable (~opt_cfg[OPT_IRQ_OFF]),
        .ack        (ack_strobe),
        .irq        (irq_out)
    );

    assign count_q = cnt_r;
endmodule

// File: rtl/rtt_checker.sv
module rtt_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [6:0]       opt_cfg,
    input logic             ack_strobe,
    input logic [CNT_W-1:0] ack_value,
    input logic [CNT_W-1:0] count_q,
    input logic             irq_out
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    a_r1_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!opt_cfg[5] && opt_cfg[3] && !ack_strobe) |=> (count_q == $past(count_q) + CNT_W'(1)));

    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_strobe |=> (count_q == $past(count_q) || count_q == $past(count_q) + CNT_W'(1)));

    a_r4_wrap_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_strobe && !opt_cfg[6] && count_q == TOP) |=> (count_q == TOP || irq_out));

    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_out && count_q != TOP) |=> !irq_out);

    a_r6_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !ack_strobe) |=> irq_out);

    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ack_strobe |=> !irq_out);

    a_r7_ack_sum: assert property (@(posedge clk) disable iff (!rst_n)
        ack_strobe |=> (count_q == CNT_W'($past(count_q) + $past(ack_value))));
endmodule

bind rtt_rollover_timer rtt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .opt_cfg    (opt_cfg),
    .ack_strobe (ack_strobe),
    .ack_value  (ack_value),
    .count_q    (count_q),
    .irq_out    (irq_out)
);

// File: tb/rtt_rollover_timer_tb.sv
module rtt_rollover_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin = 1'b0;
    logic [6:0] opt = 7'h48;
    logic       ack = 1'b0;
    logic [7:0] ack_val = 8'h00;
    logic [7:0] count_q;
    logic       irq_out;

    int    checks = 0;
    int    fails = 0;
    string cur_req = "R9";

    always #10 clk = ~clk;

    rtt_rollover_timer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_pin    (pin),
        .opt_cfg    (opt),
        .ack_strobe (ack),
        .ack_value  (ack_val),
        .count_q    (count_q),
        .irq_out    (irq_out)
    );

    // behavioural reference
    int m_cnt, m_ps, m_mask;
    bit m_irq, m_s1, m_s2, m_s3, m_ev, m_inc;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_ps = 0; m_irq = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            if (opt[5]) m_ev = opt[4] ? (!m_s2 && m_s3) : (m_s2 && !m_s3);
            else        m_ev = 1;
            m_inc = 0;
            if (opt[3]) m_inc = m_ev;
            else if (m_ev) begin
                m_mask = (1 << (int'(opt[2:0]) + 1)) - 1;
                m_inc = ((m_ps & m_mask) == m_mask);
                m_ps = (m_ps + 1) % 256;
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin;
            if (ack) begin
                m_cnt = (m_cnt + int'(ack_val)) % 256;
                m_irq = 0;
            end else if (m_inc) begin
                if (m_cnt == 255 && !opt[6]) m_irq = 1;
                m_cnt = (m_cnt + 1) % 256;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_req, "model count", int'(count_q), m_cnt);
            chk(cur_req, "model irq", int'(irq_out), int'(m_irq));
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_ack(input logic [7:0] v);
        ack = 1'b1; ack_val = v;
        @(negedge clk);
        ack = 1'b0; ack_val = 8'h00;
    endtask

    task automatic preset(input logic [7:0] target);
        do_ack(8'(target - count_q));
    endtask

    int base, last, now_c, seen;

    initial begin
        tick(3);
        chk("R9", "reset count", int'(count_q), 0);
        chk("R9", "reset irq", int'(irq_out), 0);
        rst_n = 1'b1;
        tick(1);

        // R1: internal source, divider to watchdog, code ignored
        cur_req = "R1"; opt = 7'h4D;
        base = int'(count_q); tick(10);
        chk("R1", "ten cycles", int'(count_q), (base + 10) % 256);

        // R2: divider ratios
        cur_req = "R2"; opt = 7'h40;
        base = int'(count_q); tick(20);
        chk("R2", "ratio 1:2", int'(count_q), (base + 10) % 256);
        opt = 7'h47;
        base = int'(count_q); tick(256);
        chk("R2", "ratio 1:256", int'(count_q), (base + 1) % 256);
        opt = 7'h42; tick(40);

        // R3: external pin, rising then falling, with latency
        cur_req = "R3"; opt = 7'h68; tick(4);
        base = int'(count_q);
        pin = 1'b1; tick(2);
        chk("R3", "no step before third edge", int'(count_q), base);
        tick(1);
        chk("R3", "step on third edge", int'(count_q), (base + 1) % 256);
        pin = 1'b0; tick(3);
        for (int p = 0; p < 4; p++) begin
            pin = 1'b1; tick(3); pin = 1'b0; tick(3);
        end
        tick(3);
        chk("R3", "rising edges", int'(count_q), (base + 5) % 256);
        opt = 7'h78; tick(4);
        base = int'(count_q);
        for (int p = 0; p < 4; p++) begin
            pin = 1'b1; tick(3); pin = 1'b0; tick(3);
        end
        tick(3);
        chk("R3", "falling edges", int'(count_q), (base + 4) % 256);

        // R4: wrap raises request
        cur_req = "R4"; opt = 7'h08;
        preset(8'hFE);
        chk("R4", "preset", int'(count_q), 8'hFE);
        tick(1);
        chk("R4", "no irq at FF", int'(irq_out), 0);
        tick(1);
        chk("R4", "count wrapped", int'(count_q), 0);
        chk("R4", "irq on wrap", int'(irq_out), 1);

        // R6: held until acknowledged
        cur_req = "R6"; tick(20);
        opt = 7'h48; tick(5);
        chk("R6", "irq held", int'(irq_out), 1);

        // R7: acknowledge clears, drops increment, no irq from addition
        cur_req = "R7"; base = int'(count_q);
        do_ack(8'h00);
        chk("R7", "irq cleared", int'(irq_out), 0);
        chk("R7", "increment dropped", int'(count_q), base);
        opt = 7'h08;
        preset(8'h80);
        do_ack(8'h90);
        chk("R7", "sum wraps", int'(count_q), 8'h10);
        chk("R7", "no irq from sum", int'(irq_out), 0);

        // R5: disabled requests
        cur_req = "R5"; opt = 7'h48;
        preset(8'hFE); tick(3);
        chk("R5", "count wrapped", int'(count_q), 1);
        chk("R5", "no irq", int'(irq_out), 0);

        // R8: fixed period with reload 0x27
        cur_req = "R8"; opt = 7'h08;
        last = -1; now_c = 0; seen = 0;
        while (seen < 4 && now_c < 2000) begin
            @(negedge clk);
            now_c++;
            ack = 1'b0; ack_val = 8'h00;
            if (irq_out) begin
                if (last >= 0) chk("R8", "period", now_c - last, 218);
                last = now_c; seen++;
                ack = 1'b1; ack_val = 8'h27;
            end
        end
        @(negedge clk);
        ack = 1'b0; ack_val = 8'h00;
        chk("R8", "periods seen", seen, 4);
        tick(2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule